// File: doc/BRIEF.md
# Dual-CPU Power Mode Controller

This block chooses the operating mode of a two-CPU microcontroller's power hierarchy on every clock. Each CPU subsystem is in run, sleep or halt. Each of two processor domains is on, stopped or switched off. The always-on system domain is in limited run, full run, stop or off. The inputs are the CPUs' sleep and halt requests, a map of which CPU owns peripherals in which processor domain, per-CPU power-down select bits, wakeup lines, keep-alive bits and a supply-ready flag. From these the block also derives the clock enables, the power enables and the isolation controls.

The mode of a domain depends on its own CPU. It also depends on the other CPU whenever that CPU owns a peripheral in the domain. The depth of a power-down is a vote: a single select bit asking for stop keeps the domain, or the system, in stop. Only a unanimous standby vote switches power off. After reset, and on every return from system standby, the system runs in a limited-performance state until the supply reports ready. Each processor domain isolates its outputs one cycle before its power drops and releases isolation one cycle after power returns.

Top module: `dual_cpu_pwr_ctrl`

## Requirements
- R1: CPU mode encoding is run=0, sleep=1, halt=2. A CPU in run or sleep moves to halt on a halt request when none of its wakeup lines is active. Otherwise it moves to sleep on a sleep request, and otherwise to run. A CPU in halt stays there until one of its wakeup lines is active, then goes to run. Wakeup line w belongs to CPU1 when bit w of parameter WAKE_TO_CPU1 is 1, and to CPU0 otherwise.
- R2: A CPU clock enable is high only in run. Peripheral clock bit c*N_PER+p equals enable bit c*N_PER+p in run, that enable ANDed with its low-power bit in sleep, and 0 in halt.
- R3: Domain mode encoding is on=0, stop=1, off=2. Processor domain d (hosting CPU d) is on when CPU d is not halted. It is also on when the other CPU owns a peripheral there (owner map bit c*2+d) and that CPU is not halted.
- R4: Otherwise the domain goes to stop if either CPU's select bit for it (bit c*3+d, 1 = standby) is 0, and to off only when both are 1. Its clock enable is high only when on.
- R5: System mode encoding is limited=0, full=1, stop=2, off=3. The system stays in a run mode (0 or 1) while any CPU is not halted, any wakeup line is high, or any keep-alive bit is high.
- R6: With both CPUs halted and no wakeup or keep-alive, the system parks in stop if any of the six select bits (system domain uses d=2) is 0, and in off only if all six are 1. It can move from stop to off, but never from off to stop.
- R7: Reset leaves the system in limited run. Limited run moves to full run only on a cycle with the supply-ready input high.
- R8: On leaving off, the system always enters limited run. On leaving stop, it enters full run if full run was reached since the last off, and limited run otherwise. The system clock enable is high in modes 0 and 1; the system power enable is low only in off.
- R9: When a domain is off, its isolation output rises one cycle before its power enable falls. When the domain leaves off, isolation falls one cycle after power is restored.
- R10: All mode outputs are registered. A change on the inputs appears one clock edge later in the CPU modes, and domain and system modes follow the registered CPU modes one further edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req_i | input | 2 | Per-CPU sleep request |
| halt_req_i | input | 2 | Per-CPU halt (deep-sleep) request |
| wake_i | input | N_WAKE | Wakeup lines, routed by WAKE_TO_CPU1 |
| keep_sys_i | input | 2 | Per-CPU keep-system-running bit |
| owner_map_i | input | 4 | Bit c*2+d: CPU c owns a peripheral in domain d |
| pdsel_i | input | 6 | Bit c*3+d: CPU c votes standby (1) or stop (0) for domain d (d=2 is system) |
| vready_i | input | 1 | Supply ready flag |
| per_en_i | input | 2*N_PER | Peripheral run clock enables, CPU-major |
| per_lp_i | input | 2*N_PER | Peripheral low-power clock enables |
| cpu_mode_o | output | 4 | CPU c mode in bits 2c+1:2c |
| cpu_clk_en_o | output | 2 | CPU clock enables |
| per_clk_o | output | 2*N_PER | Peripheral clock enables |
| dom_mode_o | output | 4 | Domain d mode in bits 2d+1:2d |
| dom_clk_en_o | output | 2 | Domain bus clock enables |
| dom_pwr_en_o | output | 2 | Domain power enables |
| dom_iso_o | output | 2 | Domain isolation controls |
| sys_mode_o | output | 2 | System domain mode |
| sys_clk_en_o | output | 1 | System clock enable |
| sys_pwr_en_o | output | 1 | System power enable |

## Verification
The hardest situation to reach is a full system power-down followed by a return. Both CPUs must be halted, all six select bits must vote standby, and no wakeup or keep-alive may be active for several cycles so that the isolation and power sequence plays out. A wakeup must then arrive while the supply flag is low. The stimulus holds halt requests high most of the time and sets all select bits to 1 more often than chance would. It mixes this with a directed sequence that parks the system in off, checks isolation and power, and wakes it into limited run.

// File: rtl/dcpm_pkg.sv
// Shared types for the dual-CPU power mode controller.
// Assumes exactly two CPUs, each hosted in its own processor domain.
package dcpm_pkg;
    localparam int N_CPU = 2;
    localparam int N_DOM = 2;
    localparam int N_SEL = N_CPU * (N_DOM + 1);

    typedef enum logic [1:0] {CPU_RUN = 2'd0, CPU_SLEEP = 2'd1, CPU_HALT = 2'd2} cpu_mode_t;
    typedef enum logic [1:0] {DOM_ON = 2'd0, DOM_STOP = 2'd1, DOM_OFF = 2'd2} dom_mode_t;
    typedef enum logic [1:0] {SYS_LIMIT = 2'd0, SYS_FULL = 2'd1,
                              SYS_STOP = 2'd2, SYS_OFF = 2'd3} sys_mode_t;

    function automatic logic cpu_awake(cpu_mode_t m);
        return m != CPU_HALT;
    endfunction
endpackage

// File: rtl/cpu_mode_fsm.sv
// Per-CPU mode register and clock gating.
// Assumes wake_i is already reduced to the lines routed to this CPU.
module cpu_mode_fsm
    import dcpm_pkg::*;
#(
    parameter int N_PER = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req_i,
    input  logic             halt_req_i,
    input  logic             wake_i,
    input  logic [N_PER-1:0] per_en_i,
    input  logic [N_PER-1:0] per_lp_i,
    output cpu_mode_t        mode_o,
    output logic             clk_en_o,
    output logic [N_PER-1:0] per_clk_o
);
    cpu_mode_t mode_q, mode_d;

    // Next-mode selection from the requests and the wakeup.
    always_comb begin
        if (mode_q == CPU_HALT)
            mode_d = wake_i ? CPU_RUN : CPU_HALT;
        else if (halt_req_i && !wake_i)
            mode_d = CPU_HALT;
        else if (sleep_req_i)
            mode_d = CPU_SLEEP;
        else
            mode_d = CPU_RUN;
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= CPU_RUN;
        else        mode_q <= mode_d;
    end

    // Clock gating per mode.
    always_comb begin
        clk_en_o = (mode_q == CPU_RUN);
        unique case (mode_q)
            CPU_RUN:   per_clk_o = per_en_i;
            CPU_SLEEP: per_clk_o = per_en_i & per_lp_i;
            default:   per_clk_o = '0;
        endcase
    end

    assign mode_o = mode_q;

    // R1
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == CPU_HALT && !wake_i) |=> (mode_q == CPU_HALT));
    // R1
    halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req_i && !wake_i) |=> (mode_q == CPU_HALT));
endmodule

// File: rtl/dom_mode_ctl.sv
// Processor domain mode with the isolation and power sequence.
// Assumes the CPU modes it receives are registered.
module dom_mode_ctl
    import dcpm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  cpu_mode_t    own_mode_i,
    input  cpu_mode_t    oth_mode_i,
    input  logic         oth_owns_i,
    input  logic [N_CPU-1:0] sel_i,
    output dom_mode_t    mode_o,
    output logic         clk_en_o,
    output logic         pwr_en_o,
    output logic         iso_o
);
    dom_mode_t mode_q, mode_d;
    logic      pwr_q, iso_q;

    // Domain mode from the ownership and the select vote.
    always_comb begin
        if (cpu_awake(own_mode_i) || (oth_owns_i && cpu_awake(oth_mode_i)))
            mode_d = DOM_ON;
        else if (!(&sel_i))
            mode_d = DOM_STOP;
        else
            mode_d = DOM_OFF;
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= DOM_ON;
        else        mode_q <= mode_d;
    end

    // Isolation leads power-off and trails power-on by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_q <= 1'b1;
            iso_q <= 1'b0;
        end else if (mode_q == DOM_OFF) begin
            iso_q <= 1'b1;
            pwr_q <= pwr_q & ~iso_q;
        end else begin
            pwr_q <= 1'b1;
            iso_q <= iso_q & ~pwr_q;
        end
    end

    assign mode_o   = mode_q;
    assign clk_en_o = (mode_q == DOM_ON);
    assign pwr_en_o = pwr_q;
    assign iso_o    = iso_q;

    // R9
    iso_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_q) |-> (iso_q && $past(iso_q)));
    // R9
    iso_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_q) |-> (pwr_q && $past(pwr_q)));
    // R3
    cross_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oth_owns_i && cpu_awake(oth_mode_i)) |=> (mode_q == DOM_ON));
endmodule

// File: rtl/sys_mode_ctl.sv
// Always-on system domain mode, including the limited run after reset and standby.
// Assumes the CPU modes it receives are registered.
module sys_mode_ctl
    import dcpm_pkg::*;
#(
    parameter int N_WAKE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cpu_mode_t         cpu0_mode_i,
    input  cpu_mode_t         cpu1_mode_i,
    input  logic [N_WAKE-1:0] wake_i,
    input  logic [N_CPU-1:0]  keep_i,
    input  logic [N_SEL-1:0]  sel_i,
    input  logic              vready_i,
    output sys_mode_t         mode_o,
    output logic              clk_en_o,
    output logic              pwr_en_o
);
    sys_mode_t mode_q, mode_d, park;
    logic      sup_q, sup_d, busy;

    // Activity and the parking depth from the vote of all select bits.
    always_comb begin
        busy = cpu_awake(cpu0_mode_i) || cpu_awake(cpu1_mode_i) || (|wake_i) || (|keep_i);
        park = (&sel_i) ? SYS_OFF : SYS_STOP;
    end

    // Next system mode.
    always_comb begin
        unique case (mode_q)
            SYS_LIMIT: mode_d = !busy ? park : (vready_i ? SYS_FULL : SYS_LIMIT);
            SYS_FULL:  mode_d = !busy ? park : SYS_FULL;
            SYS_STOP:  mode_d = busy ? (sup_q ? SYS_FULL : SYS_LIMIT) : park;
            default:   mode_d = busy ? SYS_LIMIT : SYS_OFF;
        endcase
        if (mode_d == SYS_FULL)     sup_d = 1'b1;
        else if (mode_d == SYS_OFF) sup_d = 1'b0;
        else                        sup_d = sup_q;
    end

    // Mode and supply-confirmed registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SYS_LIMIT;
            sup_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            sup_q  <= sup_d;
        end
    end

    assign mode_o   = mode_q;
    assign clk_en_o = (mode_q == SYS_LIMIT) || (mode_q == SYS_FULL);
    assign pwr_en_o = (mode_q != SYS_OFF);

    // R7
    limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SYS_LIMIT && !vready_i) |=> (mode_q != SYS_FULL));
    // R8
    off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SYS_OFF) |=> (mode_q == SYS_OFF || mode_q == SYS_LIMIT));
    // R5
    keep_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|keep_i) |=> (mode_q == SYS_LIMIT || mode_q == SYS_FULL));
endmodule

// File: rtl/dual_cpu_pwr_ctrl.sv
// Top of the power mode controller: two CPU mode registers, two processor
// domains and the system domain. Assumes all inputs are synchronous to clk.
module dual_cpu_pwr_ctrl
    import dcpm_pkg::*;
#(
    parameter int                N_PER        = 3,
    parameter int                N_WAKE       = 4,
    parameter logic [N_WAKE-1:0] WAKE_TO_CPU1 = 4'b1010
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              sleep_req_i,
    input  logic [1:0]              halt_req_i,
    input  logic [N_WAKE-1:0]       wake_i,
    input  logic [1:0]              keep_sys_i,
    input  logic [3:0]              owner_map_i,
    input  logic [5:0]              pdsel_i,
    input  logic                    vready_i,
    input  logic [2*N_PER-1:0]      per_en_i,
    input  logic [2*N_PER-1:0]      per_lp_i,
    output logic [3:0]              cpu_mode_o,
    output logic [1:0]              cpu_clk_en_o,
    output logic [2*N_PER-1:0]      per_clk_o,
    output logic [3:0]              dom_mode_o,
    output logic [1:0]              dom_clk_en_o,
    output logic [1:0]              dom_pwr_en_o,
    output logic [1:0]              dom_iso_o,
    output logic [1:0]              sys_mode_o,
    output logic                    sys_clk_en_o,
    output logic                    sys_pwr_en_o
);
    localparam int SEL_STRIDE = N_DOM + 1;

    cpu_mode_t cpu_mode [N_CPU];
    sys_mode_t sys_mode;

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        logic [N_WAKE-1:0] route;
        assign route = (c == 1) ? WAKE_TO_CPU1 : ~WAKE_TO_CPU1;

        cpu_mode_fsm #(.N_PER(N_PER)) i_cpu (
            .clk         (clk),
            .rst_n       (rst_n),
            .sleep_req_i (sleep_req_i[c]),
            .halt_req_i  (halt_req_i[c]),
            .wake_i      (|(wake_i & route)),
            .per_en_i    (per_en_i[c*N_PER +: N_PER]),
            .per_lp_i    (per_lp_i[c*N_PER +: N_PER]),
            .mode_o      (cpu_mode[c]),
            .clk_en_o    (cpu_clk_en_o[c]),
            .per_clk_o   (per_clk_o[c*N_PER +: N_PER])
        );
        assign cpu_mode_o[2*c +: 2] = cpu_mode[c];
    end

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        localparam int OTH = N_CPU - 1 - d;
        dom_mode_t mode;

        dom_mode_ctl i_dom (
            .clk        (clk),
            .rst_n      (rst_n),
            .own_mode_i (cpu_mode[d]),
            .oth_mode_i (cpu_mode[OTH]),
            .oth_owns_i (owner_map_i[OTH*N_DOM + d]),
            .sel_i      ({pdsel_i[SEL_STRIDE + d], pdsel_i[d]}),
            .mode_o     (mode),
            .clk_en_o   (dom_clk_en_o[d]),
            .pwr_en_o   (dom_pwr_en_o[d]),
            .iso_o      (dom_iso_o[d])
        );
        assign dom_mode_o[2*d +: 2] = mode;
    end

    sys_mode_ctl #(.N_WAKE(N_WAKE)) i_sys (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu0_mode_i (cpu_mode[0]),
        .cpu1_mode_i (cpu_mode[1]),
        .wake_i      (wake_i),
        .keep_i      (keep_sys_i),
        .sel_i       (pdsel_i),
        .vready_i    (vready_i),
        .mode_o      (sys_mode),
        .clk_en_o    (sys_clk_en_o),
        .pwr_en_o    (sys_pwr_en_o)
    );
    assign sys_mode_o = sys_mode;
endmodule

// File: tb/test_dual_cpu_pwr_ctrl.sv
module test_dual_cpu_pwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_PER = 3;
    localparam int N_WAKE = 4;
    localparam logic [N_WAKE-1:0] MAP1 = 4'b1010;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] sleep_req = '0, halt_req = '0, keep = '0;
    logic [N_WAKE-1:0] wake = '0;
    logic [3:0] owner = '0;
    logic [5:0] pdsel = '0;
    logic vready = 1'b0;
    logic [2*N_PER-1:0] per_en = '0, per_lp = '0;

    logic [3:0] cpu_mode, dom_mode;
    logic [1:0] cpu_clk, dom_clk, dom_pwr, dom_iso, sys_mode;
    logic [2*N_PER-1:0] per_clk;
    logic sys_clk, sys_pwr;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    logic done = 1'b0;

    dual_cpu_pwr_ctrl #(.N_PER(N_PER), .N_WAKE(N_WAKE), .WAKE_TO_CPU1(MAP1)) i_dual_cpu_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req), .halt_req_i(halt_req),
        .wake_i(wake), .keep_sys_i(keep), .owner_map_i(owner), .pdsel_i(pdsel),
        .vready_i(vready), .per_en_i(per_en), .per_lp_i(per_lp),
        .cpu_mode_o(cpu_mode), .cpu_clk_en_o(cpu_clk), .per_clk_o(per_clk),
        .dom_mode_o(dom_mode), .dom_clk_en_o(dom_clk), .dom_pwr_en_o(dom_pwr),
        .dom_iso_o(dom_iso), .sys_mode_o(sys_mode), .sys_clk_en_o(sys_clk),
        .sys_pwr_en_o(sys_pwr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state, built from the requirements
    logic [1:0] m_cpu [2];
    logic [1:0] m_dom [2];
    logic [1:0] m_sys;
    logic       m_sup;
    logic       m_iso [2];
    logic       m_pwr [2];

    function automatic logic [1:0] f_cpu(logic [1:0] cur, logic slp, logic hlt, logic wk);
        if (cur == 2) return wk ? 2'd0 : 2'd2;       // R1
        if (hlt && !wk) return 2'd2;
        if (slp) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [1:0] f_dom(logic [1:0] own, logic [1:0] oth, logic owns, logic [1:0] sel);
        if (own != 2 || (owns && oth != 2)) return 2'd0; // R3
        if (sel != 2'b11) return 2'd1;                   // R4
        return 2'd2;
    endfunction

    function automatic logic [1:0] f_sys(logic [1:0] cur, logic [1:0] c0, logic [1:0] c1,
                                         logic act_in, logic [5:0] sel, logic vr, logic sup);
        logic act;
        logic [1:0] pk;
        act = (c0 != 2) || (c1 != 2) || act_in;
        pk  = (&sel) ? 2'd3 : 2'd2;
        case (cur)
            2'd0: return !act ? pk : (vr ? 2'd1 : 2'd0);
            2'd1: return !act ? pk : 2'd1;
            2'd2: return act ? (sup ? 2'd1 : 2'd0) : pk;
            default: return act ? 2'd0 : 2'd3;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic [1:0] nc [2];
        logic [1:0] nd [2];
        logic [1:0] ns;
        logic ni [2];
        logic np [2];
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cpu[i] = 0; m_dom[i] = 0; m_iso[i] = 0; m_pwr[i] = 1;
            end
            m_sys = 0; m_sup = 0;
        end else begin
            nc[0] = f_cpu(m_cpu[0], sleep_req[0], halt_req[0], |(wake & ~MAP1));
            nc[1] = f_cpu(m_cpu[1], sleep_req[1], halt_req[1], |(wake & MAP1));
            nd[0] = f_dom(m_cpu[0], m_cpu[1], owner[2], {pdsel[3], pdsel[0]});
            nd[1] = f_dom(m_cpu[1], m_cpu[0], owner[1], {pdsel[4], pdsel[1]});
            ns = f_sys(m_sys, m_cpu[0], m_cpu[1], (|wake) || (|keep), pdsel, vready, m_sup);
            for (int d = 0; d < 2; d++) begin
                if (m_dom[d] == 2) begin
                    ni[d] = 1'b1; np[d] = m_pwr[d] & ~m_iso[d];
                end else begin
                    np[d] = 1'b1; ni[d] = m_iso[d] & ~m_pwr[d];
                end
            end
            if (ns == 1) m_sup = 1'b1;
            else if (ns == 3) m_sup = 1'b0;
            for (int i = 0; i < 2; i++) begin
                m_cpu[i] = nc[i]; m_dom[i] = nd[i]; m_iso[i] = ni[i]; m_pwr[i] = np[i];
            end
            m_sys = ns;
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare every output to the model (called after an edge, before new inputs)
    task automatic check_all();
        for (int c = 0; c < 2; c++) begin
            cmp("R1 cpu mode", int'(cpu_mode[2*c +: 2]), int'(m_cpu[c]));
            cmp("R2 cpu clock", int'(cpu_clk[c]), int'(m_cpu[c] == 0));
            for (int p = 0; p < N_PER; p++) begin
                int k = c*N_PER + p;
                int e = (m_cpu[c] == 0) ? int'(per_en[k]) :
                        (m_cpu[c] == 1) ? int'(per_en[k] & per_lp[k]) : 0;
                cmp("R2 peripheral clock", int'(per_clk[k]), e);
            end
        end
        for (int d = 0; d < 2; d++) begin
            cmp("R3 R4 domain mode", int'(dom_mode[2*d +: 2]), int'(m_dom[d]));
            cmp("R4 domain clock", int'(dom_clk[d]), int'(m_dom[d] == 0));
            cmp("R9 domain power", int'(dom_pwr[d]), int'(m_pwr[d]));
            cmp("R9 domain isolation", int'(dom_iso[d]), int'(m_iso[d]));
        end
        cmp("R5 R6 R7 R8 system mode", int'(sys_mode), int'(m_sys));
        cmp("R8 system clock", int'(sys_clk), int'(m_sys < 2));
        cmp("R8 system power", int'(sys_pwr), int'(m_sys != 3));
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        check_all();
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        per_en = 6'b110101; per_lp = 6'b011100;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R7 reset state: limited run, everything awake
        cmp("R7 reset system limited", int'(sys_mode), 0);
        cmp("R10 reset cpu run", int'(cpu_mode), 0);
        cmp("R9 reset power on", int'(dom_pwr), 3);
        repeat (4) step();
        cmp("R7 stays limited without ready", int'(sys_mode), 0);
        vready = 1'b1;
        step();
        cmp("R7 full run after ready", int'(sys_mode), 1);
        vready = 1'b0;

        // R10 latency, R2 sleep gating
        halt_req = 2'b01; sleep_req = 2'b10;
        #1;
        cmp("R10 no change before edge", int'(cpu_mode), 0);
        step();
        cmp("R1 cpu0 halted", int'(cpu_mode[1:0]), 2);
        cmp("R2 cpu1 sleep gating", int'(per_clk[5:3]), int'(per_en[5:3] & per_lp[5:3]));

        // R3 cross ownership keeps domain 0 on
        owner = 4'b0100; pdsel = 6'b000000;
        step(); step();
        cmp("R3 domain0 held by other owner", int'(dom_mode[1:0]), 0);
        owner = 4'b0000;
        step();
        cmp("R4 domain0 stop on stop vote", int'(dom_mode[1:0]), 1);

        // R6 R9 both halted, unanimous standby vote
        halt_req = 2'b11; sleep_req = 2'b00; pdsel = 6'b111111;
        repeat (5) step();
        cmp("R6 system off", int'(sys_mode), 3);
        cmp("R9 domain power removed", int'(dom_pwr), 0);
        cmp("R9 domain isolated", int'(dom_iso), 3);

        // R8 wake from off enters limited run even with supply flag low
        wake = 4'b0001; halt_req = 2'b10;
        step();
        cmp("R8 off exits to limited", int'(sys_mode), 0);
        cmp("R1 cpu0 woken", int'(cpu_mode[1:0]), 0);
        wake = '0;
        repeat (3) step();

        // R5 keep-alive holds system while both halt
        halt_req = 2'b11; keep = 2'b10; vready = 1'b1;
        repeat (4) step();
        cmp("R5 keep holds system run", int'(sys_mode < 2), 1);
        keep = '0;
        repeat (3) step();

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            halt_req  = {($urandom_range(99) < 70), ($urandom_range(99) < 70)};
            sleep_req = {($urandom_range(99) < 30), ($urandom_range(99) < 30)};
            wake      = ($urandom_range(99) < 10) ? N_WAKE'(1 << $urandom_range(N_WAKE-1)) : '0;
            keep      = ($urandom_range(99) < 5) ? 2'($urandom_range(3)) : '0;
            owner     = 4'($urandom);
            pdsel     = ($urandom_range(99) < 60) ? 6'h3F : 6'($urandom);
            vready    = ($urandom_range(99) < 50);
            per_en    = (2*N_PER)'($urandom);
            per_lp    = (2*N_PER)'($urandom);
            step();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule